// File: doc/BRIEF.md
# Space Vector Sector and Dwell Calculator

This block turns a frequency word and a modulation depth into the timing figures needed by a three-phase space vector modulator. A phase accumulator advances once per switching period. Its value names one of six 60° sectors and the angle inside that sector. From that angle the block derives two active-vector dwell times and the zero-vector time for half a switching period. A downstream pulse generator consumes these values.

The accumulator wraps at six sector spans, so the top bits give the sector directly. The table index comes from the upper bits of the in-sector angle. One constant table serves both dwell terms. It holds sin(θ)/sin 60° in fixed point over 0°..60°, with both end points included. T2 reads the table at index k and T1 reads it at the mirrored index. The table is built at elaboration. Run time uses only integer multiplies, adds, subtracts and shifts.

A strobe marks the start of each switching period. One result, tagged with a valid pulse, follows every strobe. When the two active times together exceed the half period, the zero time is clamped and a saturation flag is raised.

Top module: `svd_dwell_calc`

## Requirements
- R1: While rst_n is low, result_valid, saturated, sector, t1_dwell, t2_dwell and t0_dwell are all 0, and the internal phase is 0.
- R2: The phase P starts at 0 and wraps modulo M = 6·2^SUB_W. A word F ≥ M acts as F−M. On each strobe, P becomes (P + step) mod M. Each result uses the P held before that strobe's step.
- R3: sector = P / 2^SUB_W, with values 0..5. Sector 0 covers 0°..60°, and each later sector is 60° further on.
- R4: Let k = (P mod 2^SUB_W) >> (SUB_W−IDX_W) and N(j) = round(2^FRAC_W·sin(j·60°/2^IDX_W)/sin 60°). Then t1_dwell = floor(H·A·N(2^IDX_W−k) / 2^(AMP_W+FRAC_W)). H is half_period and A is amplitude, both taken at the strobe.
- R5: t2_dwell = floor(H·A·N(k) / 2^(AMP_W+FRAC_W)), with the same H, A and k as in R4.
- R6: When t1_dwell + t2_dwell ≤ H, t0_dwell = H − t1_dwell − t2_dwell and saturated = 0.
- R7: When t1_dwell + t2_dwell > H, t0_dwell = 0 and saturated = 1, and t1_dwell and t2_dwell keep their R4/R5 values.
- R8: result_valid is a one-cycle pulse for each strobe. It is high in the cycle after the second rising edge that follows the edge that sampled the strobe. Strobes on consecutive cycles give consecutive pulses. The outputs change only when result_valid is high.
- R9: Changes to amplitude, half_period and freq_word after the strobe edge do not affect that strobe's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_strobe | input | 1 | Start of a switching period; requests one result |
| freq_word | input | SUB_W+3 | Phase step per switching period |
| amplitude | input | AMP_W | Modulation depth, fraction of 2^AMP_W |
| half_period | input | TS_W | Half switching period in timer counts |
| result_valid | output | 1 | One-cycle pulse marking a new result |
| sector | output | 3 | Sector index 0..5 |
| t1_dwell | output | TS_W | Dwell of the leading active vector |
| t2_dwell | output | TS_W | Dwell of the trailing active vector |
| t0_dwell | output | TS_W | Zero-vector time |
| saturated | output | 1 | Active times exceeded the half period |

## Verification
The rising edge that samples a strobe captures the phase, amplitude and half period. The result appears after the second edge after that one, so the outputs are readable at the next falling edge. The driver pushes one expected record per strobe, built from its own phase model and the R4 table formula. It then scrambles the inputs at once, to test R9. The monitor compares fields only on falling edges where result_valid is high. It treats a pulse with no pending record as a failure. Once the driver goes idle, a pending record that never got a pulse is also a failure. Strobes on consecutive cycles check that the three stages stay aligned.

// File: rtl/svd_pkg.sv
package svd_pkg;

  localparam real SVD_PI = 3.14159265358979323846;

  // Fixed-point value of sin(j*60deg/steps)/sin(60deg), rounded to nearest.
  function automatic int svd_sin_norm(input int j, input int steps, input int frac_w);
    real ang;
    real ratio;
    ang   = (real'(j) * SVD_PI) / (3.0 * real'(steps));
    ratio = $sin(ang) / $sin(SVD_PI / 3.0);
    return $rtoi(ratio * real'(longint'(1) << frac_w) + 0.5);
  endfunction

endpackage

// File: rtl/svd_phase_acc.sv
module svd_phase_acc #(
  parameter int SUB_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [SUB_W+2:0] freq_word,
  output logic [SUB_W+2:0] phase_q
);
  localparam int          PH_W = SUB_W + 3;
  localparam logic [PH_W:0] MODULUS = (PH_W + 1)'(6) << SUB_W;

  logic [PH_W:0]   step_x;
  logic [PH_W:0]   sum_x;
  logic [PH_W-1:0] phase_d;

  always_comb begin
    step_x = {1'b0, freq_word};
    if (step_x >= MODULUS) step_x = step_x - MODULUS;
    sum_x = {1'b0, phase_q} + step_x;
    if (sum_x >= MODULUS) sum_x = sum_x - MODULUS;
    phase_d = step_en ? sum_x[PH_W-1:0] : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/svd_sine_rom.sv
module svd_sine_rom
  import svd_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int FRAC_W = 14
) (
  input  logic [IDX_W:0]  idx_a,
  input  logic [IDX_W:0]  idx_b,
  output logic [FRAC_W:0] val_a,
  output logic [FRAC_W:0] val_b
);
  localparam int STEPS = 1 << IDX_W;
  localparam int DEPTH = STEPS + 1;

  logic [FRAC_W:0] rom [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_entry
    assign rom[j] = (FRAC_W + 1)'(svd_sin_norm(j, STEPS, FRAC_W));
  end

  assign val_a = rom[idx_a];
  assign val_b = rom[idx_b];
endmodule

// File: rtl/svd_dwell_mul.sv
module svd_dwell_mul #(
  parameter int TS_W   = 16,
  parameter int AMP_W  = 12,
  parameter int FRAC_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [2:0]        in_sector,
  input  logic [TS_W-1:0]   in_half,
  input  logic [AMP_W-1:0]  in_amp,
  input  logic [FRAC_W:0]   n_t1,
  input  logic [FRAC_W:0]   n_t2,
  output logic              out_vld,
  output logic [2:0]        out_sector,
  output logic [TS_W-1:0]   out_half,
  output logic [TS_W-1:0]   out_t1,
  output logic [TS_W-1:0]   out_t2
);
  localparam int PW = TS_W + AMP_W + FRAC_W + 1;
  localparam int SH = AMP_W + FRAC_W;

  logic [PW-1:0]   prod1;
  logic [PW-1:0]   prod2;
  logic [2:0]      sector_d;
  logic [TS_W-1:0] half_d;
  logic [TS_W-1:0] t1_d;
  logic [TS_W-1:0] t2_d;

  always_comb begin
    prod1    = PW'(in_half) * PW'(in_amp) * PW'(n_t1);
    prod2    = PW'(in_half) * PW'(in_amp) * PW'(n_t2);
    sector_d = out_sector;
    half_d   = out_half;
    t1_d     = out_t1;
    t2_d     = out_t2;
    if (in_vld) begin
      sector_d = in_sector;
      half_d   = in_half;
      t1_d     = TS_W'(prod1 >> SH);
      t2_d     = TS_W'(prod2 >> SH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_sector <= '0;
      out_half   <= '0;
      out_t1     <= '0;
      out_t2     <= '0;
    end else begin
      out_vld    <= in_vld;
      out_sector <= sector_d;
      out_half   <= half_d;
      out_t1     <= t1_d;
      out_t2     <= t2_d;
    end
  end
endmodule

// File: rtl/svd_dwell_calc.sv
module svd_dwell_calc #(
  parameter int SUB_W  = 12,
  parameter int IDX_W  = 5,
  parameter int FRAC_W = 14,
  parameter int AMP_W  = 12,
  parameter int TS_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_strobe,
  input  logic [SUB_W+2:0] freq_word,
  input  logic [AMP_W-1:0] amplitude,
  input  logic [TS_W-1:0]  half_period,
  output logic             result_valid,
  output logic [2:0]       sector,
  output logic [TS_W-1:0]  t1_dwell,
  output logic [TS_W-1:0]  t2_dwell,
  output logic [TS_W-1:0]  t0_dwell,
  output logic             saturated
);
  localparam int             PH_W    = SUB_W + 3;
  localparam logic [IDX_W:0] TOP_IDX = (IDX_W + 1)'(1) << IDX_W;

  logic [PH_W-1:0] phase_q;

  // stage 1: snapshot at the strobe
  logic             s1_vld;
  logic [2:0]       s1_sector, s1_sector_d;
  logic [IDX_W-1:0] s1_idx, s1_idx_d;
  logic [AMP_W-1:0] s1_amp, s1_amp_d;
  logic [TS_W-1:0]  s1_half, s1_half_d;

  logic [IDX_W:0]  idx_t1;
  logic [IDX_W:0]  idx_t2;
  logic [FRAC_W:0] n_t1;
  logic [FRAC_W:0] n_t2;

  // stage 2: products
  logic            m_vld;
  logic [2:0]      m_sector;
  logic [TS_W-1:0] m_half;
  logic [TS_W-1:0] m_t1;
  logic [TS_W-1:0] m_t2;

  // stage 3: outputs
  logic [TS_W:0]   sum_x;
  logic            sat_calc;
  logic [TS_W-1:0] t0_calc;
  logic [2:0]      sector_d;
  logic [TS_W-1:0] t1_d, t2_d, t0_d;
  logic            sat_d;

  svd_phase_acc #(.SUB_W(SUB_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (period_strobe),
    .freq_word (freq_word),
    .phase_q   (phase_q)
  );

  always_comb begin
    s1_sector_d = s1_sector;
    s1_idx_d    = s1_idx;
    s1_amp_d    = s1_amp;
    s1_half_d   = s1_half;
    if (period_strobe) begin
      s1_sector_d = phase_q[PH_W-1:SUB_W];
      s1_idx_d    = phase_q[SUB_W-1 -: IDX_W];
      s1_amp_d    = amplitude;
      s1_half_d   = half_period;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_sector <= '0;
      s1_idx    <= '0;
      s1_amp    <= '0;
      s1_half   <= '0;
    end else begin
      s1_vld    <= period_strobe;
      s1_sector <= s1_sector_d;
      s1_idx    <= s1_idx_d;
      s1_amp    <= s1_amp_d;
      s1_half   <= s1_half_d;
    end
  end

  assign idx_t2 = {1'b0, s1_idx};
  assign idx_t1 = TOP_IDX - {1'b0, s1_idx};

  svd_sine_rom #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_rom (
    .idx_a (idx_t1),
    .idx_b (idx_t2),
    .val_a (n_t1),
    .val_b (n_t2)
  );

  svd_dwell_mul #(.TS_W(TS_W), .AMP_W(AMP_W), .FRAC_W(FRAC_W)) u_mul (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (s1_vld),
    .in_sector  (s1_sector),
    .in_half    (s1_half),
    .in_amp     (s1_amp),
    .n_t1       (n_t1),
    .n_t2       (n_t2),
    .out_vld    (m_vld),
    .out_sector (m_sector),
    .out_half   (m_half),
    .out_t1     (m_t1),
    .out_t2     (m_t2)
  );

  always_comb begin
    sum_x    = {1'b0, m_t1} + {1'b0, m_t2};
    sat_calc = sum_x > {1'b0, m_half};
    t0_calc  = sat_calc ? '0 : (m_half - sum_x[TS_W-1:0]);
    sector_d = sector;
    t1_d     = t1_dwell;
    t2_d     = t2_dwell;
    t0_d     = t0_dwell;
    sat_d    = saturated;
    if (m_vld) begin
      sector_d = m_sector;
      t1_d     = m_t1;
      t2_d     = m_t2;
      t0_d     = t0_calc;
      sat_d    = sat_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      sector       <= '0;
      t1_dwell     <= '0;
      t2_dwell     <= '0;
      t0_dwell     <= '0;
      saturated    <= 1'b0;
    end else begin
      result_valid <= m_vld;
      sector       <= sector_d;
      t1_dwell     <= t1_d;
      t2_dwell     <= t2_d;
      t0_dwell     <= t0_d;
      saturated    <= sat_d;
    end
  end
endmodule

// File: rtl/svd_dwell_calc_chk.sv
module svd_dwell_calc_chk #(
  parameter int SUB_W = 12,
  parameter int TS_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             period_strobe,
  input logic [TS_W-1:0]  half_period,
  input logic [SUB_W+2:0] phase,
  input logic             result_valid,
  input logic [2:0]       sector,
  input logic [TS_W-1:0]  t1_dwell,
  input logic [TS_W-1:0]  t2_dwell,
  input logic [TS_W-1:0]  t0_dwell,
  input logic             saturated
);
  localparam logic [SUB_W+3:0] MODULUS = (SUB_W + 4)'(6) << SUB_W;

  logic [2:0]      strobe_sh;
  logic [TS_W-1:0] half_sh0, half_sh1, half_sh2;
  logic [TS_W+1:0] total;
  logic [TS_W+1:0] active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_sh <= '0;
      half_sh0  <= '0;
      half_sh1  <= '0;
      half_sh2  <= '0;
    end else begin
      strobe_sh <= {strobe_sh[1:0], period_strobe};
      half_sh0  <= half_period;
      half_sh1  <= half_sh0;
      half_sh2  <= half_sh1;
    end
  end

  assign active = (TS_W + 2)'(t1_dwell) + (TS_W + 2)'(t2_dwell);
  assign total  = active + (TS_W + 2)'(t0_dwell);

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, phase} < MODULUS);

  assert_sector_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sector < 3'd6);

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !saturated) |-> (total == (TS_W + 2)'(half_sh2)));

  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && saturated) |-> ((t0_dwell == '0) && (active > (TS_W + 2)'(half_sh2))));

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid == strobe_sh[2]);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(t1_dwell) && $stable(t2_dwell) && $stable(t0_dwell)
                       && $stable(sector) && $stable(saturated)));
endmodule

bind svd_dwell_calc svd_dwell_calc_chk #(.SUB_W(SUB_W), .TS_W(TS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .period_strobe (period_strobe),
  .half_period   (half_period),
  .phase         (phase_q),
  .result_valid  (result_valid),
  .sector        (sector),
  .t1_dwell      (t1_dwell),
  .t2_dwell      (t2_dwell),
  .t0_dwell      (t0_dwell),
  .saturated     (saturated)
);

// File: tb/test_svd_dwell_calc.sv
module test_svd_dwell_calc;
  localparam int CLK_PERIOD = 10;
  localparam int SUB_W  = 12;
  localparam int IDX_W  = 5;
  localparam int FRAC_W = 14;
  localparam int AMP_W  = 12;
  localparam int TS_W   = 16;
  localparam int MODV   = 6 << SUB_W;
  localparam int WATCHDOG = 20000;

  typedef struct {
    int sec;
    int t1;
    int t2;
    int t0;
    int sat;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic             period_strobe;
  logic [SUB_W+2:0] freq_word;
  logic [AMP_W-1:0] amplitude;
  logic [TS_W-1:0]  half_period;
  logic             result_valid;
  logic [2:0]       sector;
  logic [TS_W-1:0]  t1_dwell, t2_dwell, t0_dwell;
  logic             saturated;

  exp_t exp_q[$];
  int   n_checks;
  int   n_fail;
  int   ref_phase;
  int   cycles;
  bit   done;

  svd_dwell_calc #(.SUB_W(SUB_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W),
                   .AMP_W(AMP_W), .TS_W(TS_W)) i_svd_dwell_calc (
    .clk (clk), .rst_n (rst_n), .period_strobe (period_strobe),
    .freq_word (freq_word), .amplitude (amplitude), .half_period (half_period),
    .result_valid (result_valid), .sector (sector), .t1_dwell (t1_dwell),
    .t2_dwell (t2_dwell), .t0_dwell (t0_dwell), .saturated (saturated)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint nval(input int j);
    real pi;
    real r;
    pi = 3.14159265358979323846;
    r  = $sin(real'(j) * pi / (3.0 * real'(1 << IDX_W))) / $sin(pi / 3.0);
    return longint'($rtoi(r * real'(1 << FRAC_W) + 0.5));
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Driver: one strobe per call; consecutive calls give back-to-back strobes.
  task automatic strobe_once(input int f, input int a, input int h);
    exp_t e;
    int   k;
    longint p1, p2;
    @(negedge clk);
    freq_word     = (SUB_W + 3)'(f);
    amplitude     = AMP_W'(a);
    half_period   = TS_W'(h);
    period_strobe = 1'b1;
    k    = (ref_phase % (1 << SUB_W)) >> (SUB_W - IDX_W);
    p1   = longint'(h) * longint'(a) * nval((1 << IDX_W) - k);
    p2   = longint'(h) * longint'(a) * nval(k);
    e.sec = ref_phase / (1 << SUB_W);
    e.t1  = int'(p1 >>> (AMP_W + FRAC_W));
    e.t2  = int'(p2 >>> (AMP_W + FRAC_W));
    e.sat = (e.t1 + e.t2 > h) ? 1 : 0;
    e.t0  = e.sat ? 0 : h - e.t1 - e.t2;
    exp_q.push_back(e);
    ref_phase = (ref_phase + ((f >= MODV) ? f - MODV : f)) % MODV;
  endtask

  // R9: inputs are scrambled right after the strobe edge; results must not move.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      period_strobe = 1'b0;
      amplitude     = '0;
      half_period   = '1;
      freq_word     = '1;
    end
  endtask

  // Monitor: pops one expected record per valid pulse.
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R2/R3 sector", int'(sector), e.sec);
        check("R4 t1", int'(t1_dwell), e.t1);
        check("R5 t2", int'(t2_dwell), e.t2);
        check("R6/R7 t0", int'(t0_dwell), e.t0);
        check("R7 saturated", int'(saturated), e.sat);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG) begin
      done = 1'b1;
      check("watchdog expired", 1, 0);
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; ref_phase = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; period_strobe = 1'b0;
    freq_word = '0; amplitude = '0; half_period = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(result_valid), 0);
    check("R1 t1 in reset", int'(t1_dwell), 0);
    check("R1 t2 in reset", int'(t2_dwell), 0);
    check("R1 t0 in reset", int'(t0_dwell), 0);
    check("R1 sat in reset", int'(saturated), 0);
    check("R1 sector in reset", int'(sector), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    strobe_once(0, 2048, 1000);            // R4: k=0, T1=500, T2=0, T0=500
    idle(4);
    strobe_once(6144, 4095, 1000);         // R6: near-full depth at sector start
    idle(4);
    strobe_once(28672, 4095, 1000);        // R2 word above modulus; R7 mid-sector saturation
    idle(4);
    strobe_once(0, 0, 777);                // R6: zero depth gives T0 = half period
    idle(1);
    strobe_once(4096, 4095, 65535);        // R5: full-width half period
    strobe_once(4096, 3000, 40000);        // R8: back-to-back strobes
    strobe_once(4096, 1000, 12345);
    idle(4);
    for (int i = 0; i < 24; i++) begin     // R3: walk all sectors and wrap
      strobe_once(3001 + i * 37, (i * 211 + 900) % 4096, 200 + i * 53);
      if (i % 3 == 0) idle(3);
    end
    idle(8);
    check("R8 results pending", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule